// File: doc/BRIEF.md
# Multi-Core Doorbell Message Unit

This unit lets the cores of a cluster ring each other. Every core owns one command lane (lane i belongs to core i). On that lane it can post a 32-bit message word either as a send or as a clear. Bits 31:27 of the word hold a type code, bit 26 is a broadcast flag, and bits 13:0 hold a destination processor tag. Each core also presents its own processor ID, and a send reaches every core whose ID matches the tag.

A send of a supported type raises a normal or critical doorbell pending bit in every addressed core. It also asserts that core's hard-interrupt request. A clear decodes its type the same way but only drops the matching pending bit of the core that issued it. A per-core acknowledge input wipes both pending bits of that core at once. All state is registered, so each command shows on the outputs one clock after it is presented. All lanes are served in the same cycle.

Top module: `dbmu_unit`

## Requirements
- R1: The type field (message bits 31:27) decodes code 0 as a normal doorbell and code 1 as a critical doorbell. Every other code is unsupported and has no action, including the guest-doorbell codes 2, 3 and 4.
- R2: A send of a supported type sets the decoded pending bit, one clock later, in every core whose processor ID equals the tag (message bits 13:0). When bit 26 is 1, it sets the bit in all cores regardless of the tag. Several cores with the same ID are all hit.
- R3: Every core hit by a send has its hard-interrupt output high one clock later. The output then stays high until that core has no pending bit left, and it is never high while both pending bits of the core are low.
- R4: A clear posted on lane i removes only the decoded pending bit of core i. The tag and broadcast fields are ignored, and all other cores and the other bit are left unchanged.
- R5: A send or clear whose type is unsupported changes no pending bit and no interrupt output anywhere.
- R6: When a send and a clear address the same core and the same bit in one cycle, the bit ends up set.
- R7: The acknowledge input of a core clears both of its pending bits and its interrupt output one clock later. A send that hits the same core in the same cycle still sets its bit.
- R8: While reset (active low) is asserted, all pending bits and interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | N | Command strobe per lane (lane i = core i) |
| cmd_clear_i | input | N | Per lane: 1 = clear command, 0 = send command |
| cmd_msg_i | input | N*32 | Message word per lane, lane i at bits 32*i+31 : 32*i |
| core_id_i | input | N*14 | Processor ID per core, core i at bits 14*i+13 : 14*i |
| ack_i | input | N | Delivery acknowledge per core, clears both pending bits |
| db_pend_o | output | N | Normal doorbell pending bit per core |
| cdb_pend_o | output | N | Critical doorbell pending bit per core |
| hirq_o | output | N | Hard-interrupt request per core |

## Verification
Two conflicts can land on the same core in one cycle: a send from one lane with a clear of the same bit from the target's own lane, and a send with that core's acknowledge. The bench provokes both by driving the two lanes, or the lane and the acknowledge, in the same cycle. It then checks that the sent bit ends up set, while the acknowledge still removes the bit that was not sent. Bystander cores that were addressed by the same broadcast or tag are checked in the same sample.

// File: rtl/dbmu_pkg.sv
package dbmu_pkg;

    // Supported type codes of the message type field
    localparam int unsigned CODE_DB  = 0;
    localparam int unsigned CODE_CDB = 1;

    // Registered state of one core
    typedef struct packed {
        logic db;
        logic cdb;
        logic irq;
    } core_st_t;

endpackage

// File: rtl/dbmu_decode.sv
module dbmu_decode #(
    parameter int unsigned MSG_W     = 32,
    parameter int unsigned TYPE_HI   = 31,
    parameter int unsigned TYPE_LO   = 27,
    parameter int unsigned BCAST_BIT = 26,
    parameter int unsigned TAG_HI    = 13,
    parameter int unsigned TAG_LO    = 0,
    localparam int unsigned TYPE_W   = TYPE_HI - TYPE_LO + 1,
    localparam int unsigned TAG_W    = TAG_HI - TAG_LO + 1
) (
    input  logic             valid_i,
    input  logic             clear_i,
    input  logic [MSG_W-1:0] msg_i,
    output logic             send_db_o,
    output logic             send_cdb_o,
    output logic             clr_db_o,
    output logic             clr_cdb_o,
    output logic             bcast_o,
    output logic [TAG_W-1:0] tag_o
);
    import dbmu_pkg::*;

    logic [TYPE_W-1:0] type_f;
    logic              is_db;
    logic              is_cdb;

    always_comb begin
        type_f     = msg_i[TYPE_HI:TYPE_LO];
        is_db      = (type_f == TYPE_W'(CODE_DB));
        is_cdb     = (type_f == TYPE_W'(CODE_CDB));
        send_db_o  = valid_i && !clear_i && is_db;
        send_cdb_o = valid_i && !clear_i && is_cdb;
        clr_db_o   = valid_i &&  clear_i && is_db;
        clr_cdb_o  = valid_i &&  clear_i && is_cdb;
        bcast_o    = msg_i[BCAST_BIT];
        tag_o      = msg_i[TAG_HI:TAG_LO];
    end

endmodule

// File: rtl/dbmu_route.sv
module dbmu_route #(
    parameter int unsigned N     = 4,
    parameter int unsigned TAG_W = 14
) (
    input  logic [N-1:0]       send_db_i,
    input  logic [N-1:0]       send_cdb_i,
    input  logic [N-1:0]       bcast_i,
    input  logic [N*TAG_W-1:0] tag_i,
    input  logic [TAG_W-1:0]   my_id_i,
    output logic               set_db_o,
    output logic               set_cdb_o
);
    logic [N-1:0] addr_me;

    always_comb begin
        set_db_o  = 1'b0;
        set_cdb_o = 1'b0;
        for (int l = 0; l < N; l++) begin
            addr_me[l] = bcast_i[l] || (tag_i[l*TAG_W +: TAG_W] == my_id_i);
            set_db_o   = set_db_o  || (send_db_i[l]  && addr_me[l]);
            set_cdb_o  = set_cdb_o || (send_cdb_i[l] && addr_me[l]);
        end
    end

endmodule

// File: rtl/dbmu_core.sv
module dbmu_core (
    input  logic clk,
    input  logic rst_n,
    input  logic set_db_i,
    input  logic set_cdb_i,
    input  logic clr_db_i,
    input  logic clr_cdb_i,
    input  logic ack_i,
    output logic db_o,
    output logic cdb_o,
    output logic irq_o
);
    import dbmu_pkg::*;

    core_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // Sets are applied last so a same-cycle send beats clear and ack
        st_d.db  = (st_q.db  && !clr_db_i  && !ack_i) || set_db_i;
        st_d.cdb = (st_q.cdb && !clr_cdb_i && !ack_i) || set_cdb_i;
        st_d.irq = set_db_i || set_cdb_i || (st_q.irq && (st_d.db || st_d.cdb));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign db_o  = st_q.db;
    assign cdb_o = st_q.cdb;
    assign irq_o = st_q.irq;

endmodule

// File: rtl/dbmu_unit.sv
module dbmu_unit #(
    parameter int unsigned N         = 4,
    parameter int unsigned MSG_W     = 32,
    parameter int unsigned TYPE_HI   = 31,
    parameter int unsigned TYPE_LO   = 27,
    parameter int unsigned BCAST_BIT = 26,
    parameter int unsigned TAG_HI    = 13,
    parameter int unsigned TAG_LO    = 0,
    localparam int unsigned TAG_W    = TAG_HI - TAG_LO + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       cmd_valid_i,
    input  logic [N-1:0]       cmd_clear_i,
    input  logic [N*MSG_W-1:0] cmd_msg_i,
    input  logic [N*TAG_W-1:0] core_id_i,
    input  logic [N-1:0]       ack_i,
    output logic [N-1:0]       db_pend_o,
    output logic [N-1:0]       cdb_pend_o,
    output logic [N-1:0]       hirq_o
);
    logic [N-1:0]       send_db;
    logic [N-1:0]       send_cdb;
    logic [N-1:0]       clr_db;
    logic [N-1:0]       clr_cdb;
    logic [N-1:0]       bcast;
    logic [N*TAG_W-1:0] tags;
    logic [N-1:0]       set_db;
    logic [N-1:0]       set_cdb;

    for (genvar l = 0; l < N; l++) begin : g_lane
        dbmu_decode #(
            .MSG_W(MSG_W), .TYPE_HI(TYPE_HI), .TYPE_LO(TYPE_LO),
            .BCAST_BIT(BCAST_BIT), .TAG_HI(TAG_HI), .TAG_LO(TAG_LO)
        ) u_dec (
            .valid_i    (cmd_valid_i[l]),
            .clear_i    (cmd_clear_i[l]),
            .msg_i      (cmd_msg_i[l*MSG_W +: MSG_W]),
            .send_db_o  (send_db[l]),
            .send_cdb_o (send_cdb[l]),
            .clr_db_o   (clr_db[l]),
            .clr_cdb_o  (clr_cdb[l]),
            .bcast_o    (bcast[l]),
            .tag_o      (tags[l*TAG_W +: TAG_W])
        );
    end

    for (genvar c = 0; c < N; c++) begin : g_core
        dbmu_route #(.N(N), .TAG_W(TAG_W)) u_route (
            .send_db_i  (send_db),
            .send_cdb_i (send_cdb),
            .bcast_i    (bcast),
            .tag_i      (tags),
            .my_id_i    (core_id_i[c*TAG_W +: TAG_W]),
            .set_db_o   (set_db[c]),
            .set_cdb_o  (set_cdb[c])
        );

        dbmu_core u_core (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_db_i  (set_db[c]),
            .set_cdb_i (set_cdb[c]),
            .clr_db_i  (clr_db[c]),
            .clr_cdb_i (clr_cdb[c]),
            .ack_i     (ack_i[c]),
            .db_o      (db_pend_o[c]),
            .cdb_o     (cdb_pend_o[c]),
            .irq_o     (hirq_o[c])
        );
    end

endmodule

// File: rtl/dbmu_checker.sv
module dbmu_checker #(
    parameter int unsigned N         = 4,
    parameter int unsigned MSG_W     = 32,
    parameter int unsigned TYPE_HI   = 31,
    parameter int unsigned TYPE_LO   = 27,
    parameter int unsigned BCAST_BIT = 26,
    parameter int unsigned TAG_HI    = 13,
    parameter int unsigned TAG_LO    = 0,
    localparam int unsigned TAG_W    = TAG_HI - TAG_LO + 1,
    localparam int unsigned TYPE_W   = TYPE_HI - TYPE_LO + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N-1:0]       cmd_valid_i,
    input logic [N-1:0]       cmd_clear_i,
    input logic [N*MSG_W-1:0] cmd_msg_i,
    input logic [N*TAG_W-1:0] core_id_i,
    input logic [N-1:0]       ack_i,
    input logic [N-1:0]       db_pend_o,
    input logic [N-1:0]       cdb_pend_o,
    input logic [N-1:0]       hirq_o
);
    logic [N-1:0] good_type;
    logic [N-1:0] any_effect;
    logic         any_good_send;
    logic         lane0_bcast_db;

    always_comb begin
        any_good_send = 1'b0;
        for (int l = 0; l < N; l++) begin
            good_type[l]  = (cmd_msg_i[l*MSG_W + TYPE_LO +: TYPE_W] <= TYPE_W'(1));
            any_effect[l] = cmd_valid_i[l] && good_type[l];
            any_good_send = any_good_send || (any_effect[l] && !cmd_clear_i[l]);
        end
        lane0_bcast_db = cmd_valid_i[0] && !cmd_clear_i[0]
                      && (cmd_msg_i[TYPE_LO +: TYPE_W] == '0)
                      && cmd_msg_i[BCAST_BIT];
    end

    // R5: nothing but unsupported commands and no ack -> all state holds
    assert_ignored_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (any_effect == '0 && ack_i == '0) |=>
            ($stable(db_pend_o) && $stable(cdb_pend_o) && $stable(hirq_o)));

    // R2: broadcast normal doorbell reaches every core
    assert_bcast_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lane0_bcast_db |=> (&db_pend_o));

    for (genvar c = 0; c < N; c++) begin : g_chk
        // R3: interrupt request only while something is pending
        assert_irq_has_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
            hirq_o[c] |-> (db_pend_o[c] || cdb_pend_o[c]));

        // R4: without a send, own clear or ack, a core's bits hold
        assert_clear_own_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!any_good_send && !ack_i[c] && !(cmd_valid_i[c] && cmd_clear_i[c])) |=>
                ($stable(db_pend_o[c]) && $stable(cdb_pend_o[c])));

        // R7: ack without any competing send empties the core
        assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i[c] && !any_good_send) |=>
                (!db_pend_o[c] && !cdb_pend_o[c] && !hirq_o[c]));
    end

endmodule

bind dbmu_unit dbmu_checker #(
    .N(N), .MSG_W(MSG_W), .TYPE_HI(TYPE_HI), .TYPE_LO(TYPE_LO),
    .BCAST_BIT(BCAST_BIT), .TAG_HI(TAG_HI), .TAG_LO(TAG_LO)
) u_dbmu_chk (.*);

// File: tb/dbmu_unit_test.sv
module dbmu_unit_test;
    localparam int CLK_P = 10;
    localparam int NC    = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC-1:0]     cmd_valid_i = '0;
    logic [NC-1:0]     cmd_clear_i = '0;
    logic [NC*32-1:0]  cmd_msg_i = '0;
    logic [NC*14-1:0]  core_id_i = {14'h3FFF, 14'd9, 14'd9, 14'd5};
    logic [NC-1:0]     ack_i = '0;
    logic [NC-1:0]     db_pend_o, cdb_pend_o, hirq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    dbmu_unit #(.N(NC)) uut (.*);

    always #(CLK_P/2) clk = ~clk;

    typedef struct packed {
        logic        vld;
        logic [1:0]  lane;
        logic        clr;
        logic [31:0] msg;
        logic [3:0]  ack;
        logic [3:0]  edb;
        logic [3:0]  ecdb;
        logic [3:0]  eirq;
        logic [3:0]  req;
    } vec_t;

    // Core IDs: core0=5, core1=9, core2=9, core3=0x3FFF. Bits below = core index.
    localparam vec_t VECS [14] = '{
        '{1'b1, 2'd0, 1'b0, 32'h0000_0009, 4'h0, 4'h6, 4'h0, 4'h6, 4'd2}, // R2 R3 tag 9 hits two cores
        '{1'b1, 2'd1, 1'b0, 32'h0800_0005, 4'h0, 4'h6, 4'h1, 4'h7, 4'd1}, // R1 critical code
        '{1'b1, 2'd3, 1'b0, 32'h1400_0009, 4'h0, 4'h6, 4'h1, 4'h7, 4'd5}, // R5 guest code 2 bcast
        '{1'b1, 2'd0, 1'b0, 32'h2000_0005, 4'h0, 4'h6, 4'h1, 4'h7, 4'd5}, // R5 guest code 4
        '{1'b1, 2'd2, 1'b1, 32'h0000_0000, 4'h0, 4'h2, 4'h1, 4'h3, 4'd4}, // R4 R3 own clear, irq drops
        '{1'b1, 2'd1, 1'b1, 32'h0800_0005, 4'h0, 4'h2, 4'h1, 4'h3, 4'd4}, // R4 core0 cdb untouched
        '{1'b1, 2'd0, 1'b1, 32'hF800_0000, 4'h0, 4'h2, 4'h1, 4'h3, 4'd5}, // R5 code 31 clear
        '{1'b1, 2'd2, 1'b0, 32'h0C00_0000, 4'h0, 4'h2, 4'hF, 4'hF, 4'd2}, // R2 broadcast critical
        '{1'b1, 2'd3, 1'b0, 32'h0000_3FFF, 4'h0, 4'hA, 4'hF, 4'hF, 4'd2}, // R2 full-width tag
        '{1'b0, 2'd0, 1'b0, 32'h0000_0000, 4'h5, 4'hA, 4'hA, 4'hA, 4'd7}, // R7 ack cores 0,2
        '{1'b1, 2'd3, 1'b1, 32'h0800_0000, 4'h0, 4'hA, 4'h2, 4'hA, 4'd4}, // R4 R3 irq held by db
        '{1'b1, 2'd3, 1'b0, 32'h0000_1234, 4'h0, 4'hA, 4'h2, 4'hA, 4'd2}, // R2 no match
        '{1'b1, 2'd1, 1'b1, 32'h0400_0009, 4'h0, 4'h8, 4'h2, 4'hA, 4'd4}, // R4 bcast field ignored
        '{1'b1, 2'd1, 1'b1, 32'h0800_0000, 4'h0, 4'h8, 4'h0, 4'h8, 4'd3}  // R3 last bit gone
    };

    task automatic chk(input string tag, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic [3:0] edb,
                           input logic [3:0] ecdb, input logic [3:0] eirq);
        chk(tag, "db",  db_pend_o,  edb);
        chk(tag, "cdb", cdb_pend_o, ecdb);
        chk(tag, "irq", hirq_o,     eirq);
    endtask

    task automatic idle();
        cmd_valid_i = '0;
        cmd_clear_i = '0;
        cmd_msg_i   = '0;
        ack_i       = '0;
    endtask

    // Drive on negedge, sample 1 time unit after the next posedge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        chk_all("R8", 4'h0, 4'h0, 4'h0);          // R8 during reset
        rst_n = 1'b1;
        step();
        chk_all("R8", 4'h0, 4'h0, 4'h0);          // R8 after release

        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            idle();
            cmd_valid_i[VECS[i].lane] = VECS[i].vld;
            cmd_clear_i[VECS[i].lane] = VECS[i].clr;
            cmd_msg_i[VECS[i].lane*32 +: 32] = VECS[i].msg;
            ack_i = VECS[i].ack;
            step();
            chk_all($sformatf("R%0d vec%0d", VECS[i].req, i),
                    VECS[i].edb, VECS[i].ecdb, VECS[i].eirq);
        end

        // R6: lane0 sends doorbell to tag 9 while core1 clears its doorbell
        @(negedge clk);
        idle();
        cmd_valid_i = 4'b0011;
        cmd_clear_i = 4'b0010;
        cmd_msg_i[31:0]  = 32'h0000_0009;
        cmd_msg_i[63:32] = 32'h0000_0000;
        step();
        chk_all("R6", 4'hE, 4'h0, 4'hE);

        // R7: ack core1 while lane0 sends critical to tag 9
        @(negedge clk);
        idle();
        cmd_valid_i = 4'b0001;
        cmd_msg_i[31:0] = 32'h0800_0009;
        ack_i = 4'b0010;
        step();
        chk_all("R7", 4'hC, 4'h6, 4'hE);

        // R5: idle cycle leaves everything unchanged
        @(negedge clk);
        idle();
        step();
        chk_all("R5", 4'hC, 4'h6, 4'hE);

        // R8: reset in mid-run empties every core
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk_all("R8", 4'h0, 4'h0, 4'h0);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        chk_all("R8", 4'h0, 4'h0, 4'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule